// File: doc/BRIEF.md
# 1-Wire ROM Search Triplet Sequencer

This block carries out one branch step of a 1-Wire ROM search in hardware. On a start request it runs three bit slots on a single-wire bit engine. The first slot reads the ID bit and the second reads its complement. The block then chooses a branch direction from the two bits and the caller's preferred direction, and writes that direction in a third slot. It reports the step as a 3-bit code with a one-cycle done pulse. Search bookkeeping stays with the caller: the last discrepancy position and the assembly of the ROM code.

The bit engine is reached through a start/complete handshake. The sequencer pulses `slot_go` with `slot_wr` set to select a write or a read. For a write it also presents the bit to send on `slot_wbit`. It then waits for the matching completion: `slot_rx_done` with `slot_rbit` for a read, or `slot_tx_done` for a write. A completion that does not arrive within `WAIT_LIMIT` cycles aborts the step and flags an error.

Top module: `search_triplet_seq`

## Requirements
- R1: A step issues its slots in a fixed order: read (ID bit), read (complement bit), then write (direction). Each `slot_go` is a one-cycle pulse, with `slot_wr`=0 for reads and 1 for the write. No slot is issued in a cycle that carries `step_done`.
- R2: When both bits read are 1, the step ends with code 3'b011, no error and no write slot.
- R3: When both bits read are 0, the direction is the `step_pref` value sampled in the cycle the request was accepted. The same value is written on `slot_wbit`, and the code is 3'b100 for direction 1 and 3'b000 for direction 0.
- R4: When exactly one bit read is 1, the direction equals the ID bit, giving code 3'b101 (ID=1) or 3'b010 (ID=0).
- R5: The code holds the ID bit in bit 0, the complement bit in bit 1 and the direction in bit 2. A read slot advances only on `slot_rx_done` and the write slot only on `slot_tx_done`. A completion of the other kind, or one that arrives while `slot_go` is high, is ignored.
- R6: If a slot's completion is not seen at any of the `WAIT_LIMIT` clock edges after its `slot_go` is registered, the step ends at once with code 3'b011, `step_err`=1 and no further slot.
- R7: `step_req` is accepted only when no step is in progress. A request made during a step has no effect on its slots or result.
- R8: `step_done` is a one-cycle pulse and `step_code` is valid in that cycle. `step_err` is high only together with `step_done`.
- R9: After reset `step_done`, `step_err` and `slot_go` are 0 and `step_code` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_req | input | 1 | Request one search step |
| step_pref | input | 1 | Direction to take when both branches exist |
| step_done | output | 1 | One-cycle pulse: step finished |
| step_code | output | 3 | {direction, complement bit, ID bit}; 3'b011 for no response or abort |
| step_err | output | 1 | Step aborted on a completion timeout (with `step_done`) |
| slot_go | output | 1 | Start one bit slot on the bit engine |
| slot_wr | output | 1 | 1: write slot, 0: read slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_rx_done | input | 1 | Bit engine finished a read |
| slot_rbit | input | 1 | Bit value read, valid with `slot_rx_done` |
| slot_tx_done | input | 1 | Bit engine finished a write |

## Verification
The bench targets the four bit combinations with both preferred directions. A design that wrote the branch bit in the no-response case, or that sampled the preference late, would put a wrong bit on the wire or an extra slot in the trace. It places completions one cycle inside and one cycle outside the timeout window, where an off-by-one counter either aborts a good step or accepts a late one. It also sends completions of the wrong kind while a slot is pending and repeats requests mid-step, so that a design which trusts any completion or restarts when busy shows stray slots or early done pulses against the cycle model.

// File: rtl/sstep_pkg.sv
package sstep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_ID  = 2'd1,
        ST_RD_CMP = 2'd2,
        ST_WR_DIR = 2'd3
    } sstep_state_e;

    localparam logic [2:0] CODE_NONE = 3'b011;

    typedef struct packed {
        sstep_state_e st;
        logic         go;
        logic         wr;
        logic         wbit;
        logic         done;
        logic         err;
        logic [2:0]   code;
        logic         pref;
        logic         id;
    } sstep_regs_s;

endpackage

// File: rtl/sstep_decide.sv
module sstep_decide (
    input  logic       id_bit,
    input  logic       cmp_bit,
    input  logic       pref,
    output logic       none,
    output logic       dir,
    output logic [2:0] code
);
    always_comb begin
        none = id_bit & cmp_bit;
        dir  = (id_bit ^ cmp_bit) ? id_bit : pref;
        code = {dir, cmp_bit, id_bit};
    end
endmodule

// File: rtl/sstep_watch.sv
module sstep_watch #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = (cnt_q == LAST);
        if (clr)
            cnt_d = '0;
        else if (expired)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired && !clr |=> expired);
endmodule

// File: rtl/search_triplet_seq.sv
module search_triplet_seq
    import sstep_pkg::*;
#(
    parameter int WAIT_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_req,
    input  logic       step_pref,
    output logic       step_done,
    output logic [2:0] step_code,
    output logic       step_err,
    output logic       slot_go,
    output logic       slot_wr,
    output logic       slot_wbit,
    input  logic       slot_rx_done,
    input  logic       slot_rbit,
    input  logic       slot_tx_done
);
    sstep_regs_s r_d, r_q;
    logic        wd_clr, wd_expired;
    logic        dec_none, dec_dir;
    logic [2:0]  dec_code;
    logic        rd_ack, wr_ack;

    sstep_watch #(.LIMIT(WAIT_LIMIT)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wd_clr),
        .expired (wd_expired)
    );

    sstep_decide u_decide (
        .id_bit  (r_q.id),
        .cmp_bit (slot_rbit),
        .pref    (r_q.pref),
        .none    (dec_none),
        .dir     (dec_dir),
        .code    (dec_code)
    );

    always_comb begin
        r_d    = r_q;
        r_d.go   = 1'b0;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        wd_clr = 1'b0;
        rd_ack = slot_rx_done && !r_q.go;
        wr_ack = slot_tx_done && !r_q.go;

        unique case (r_q.st)
            ST_IDLE: begin
                if (step_req) begin
                    r_d.st   = ST_RD_ID;
                    r_d.go   = 1'b1;
                    r_d.wr   = 1'b0;
                    r_d.pref = step_pref;
                    wd_clr   = 1'b1;
                end
            end
            ST_RD_ID: begin
                if (rd_ack) begin
                    r_d.id = slot_rbit;
                    r_d.st = ST_RD_CMP;
                    r_d.go = 1'b1;
                    r_d.wr = 1'b0;
                    wd_clr = 1'b1;
                end else if (wd_expired) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.code = CODE_NONE;
                end
            end
            ST_RD_CMP: begin
                if (rd_ack) begin
                    if (dec_none) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.code = CODE_NONE;
                    end else begin
                        r_d.st   = ST_WR_DIR;
                        r_d.code = dec_code;
                        r_d.go   = 1'b1;
                        r_d.wr   = 1'b1;
                        r_d.wbit = dec_dir;
                        wd_clr   = 1'b1;
                    end
                end else if (wd_expired) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.code = CODE_NONE;
                end
            end
            ST_WR_DIR: begin
                if (wr_ack) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else if (wd_expired) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.code = CODE_NONE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, code: 3'b000, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign step_done = r_q.done;
    assign step_code = r_q.code;
    assign step_err  = r_q.err;
    assign slot_go   = r_q.go;
    assign slot_wr   = r_q.wr;
    assign slot_wbit = r_q.wbit;

    // R1
    go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_go |=> !slot_go);

    // R1
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> !slot_go);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);

    // R6
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_err |-> (step_done && step_code == 3'b011));

    // R5
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> (step_code == 3'b000 || step_code == 3'b010 ||
                       step_code == 3'b011 || step_code == 3'b100 ||
                       step_code == 3'b101));

    // R4
    forced_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && (step_code[0] ^ step_code[1])) |-> (step_code[2] == step_code[0]));

    // R3
    wbit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && !step_err && step_code != 3'b011) |-> (slot_wbit == step_code[2]));
endmodule

// File: tb/test_search_triplet_seq.sv
`timescale 1ns/1ps
module test_search_triplet_seq;
    localparam int LIM = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_req = 1'b0;
    logic       step_pref = 1'b0;
    logic       slot_rx_done = 1'b0;
    logic       slot_rbit = 1'b0;
    logic       slot_tx_done = 1'b0;
    logic       step_done, step_err, slot_go, slot_wr, slot_wbit;
    logic [2:0] step_code;

    always #4 clk = ~clk;

    search_triplet_seq #(.WAIT_LIMIT(LIM)) i_search_triplet_seq (
        .clk, .rst_n, .step_req, .step_pref, .step_done, .step_code, .step_err,
        .slot_go, .slot_wr, .slot_wbit, .slot_rx_done, .slot_rbit, .slot_tx_done
    );

    int n_vec = 0;
    int n_bad = 0;
    bit run = 0;

    // step configuration
    bit    c_id, c_cmp, c_pref, c_spam, c_spur;
    int    c_lat[3];
    int    c_drop;
    string cur_tag = "R1";
    bit    start_pend = 0;
    bit    step_end = 0;

    // responder state
    int sidx = 0, rcnt = 0;
    bit rpend = 0, rkind = 0, rval = 0;

    // reference model state
    int       m_ph = 0, m_w = 0;
    bit       m_id, m_cmp, m_pref, m_dir;
    bit       e_go = 0, e_wr = 0, e_wbit = 0, e_done = 0, e_err = 0;
    bit [2:0] e_code = 3'b000;

    function automatic string code_tag(input bit [2:0] c, input bit err);
        if (err) return "R6";
        if (c == 3'b011) return "R2";
        if (c == 3'b000 || c == 3'b100) return "R3";
        return "R4";
    endfunction

    task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tg, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tg, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (run) begin
        bit go_now, fin;
        bit rx_v, tx_v, rb_v, req_v, pf_v;
        // compare against the previous cycle's prediction
        chk({2'b0, step_done}, {2'b0, e_done}, "R8", "done");
        chk({2'b0, step_err}, {2'b0, e_err}, "R6", "err");
        chk({2'b0, slot_go}, {2'b0, e_go}, cur_tag, "slot_go");
        if (e_go) chk({2'b0, slot_wr}, {2'b0, e_wr}, "R1", "slot_wr");
        if (e_go && e_wr) chk({2'b0, slot_wbit}, {2'b0, e_wbit}, "R3", "slot_wbit");
        if (e_done) chk(step_code, e_code, code_tag(e_code, e_err), "code (R5 layout)");

        // bit engine responder
        rx_v = 0; tx_v = 0; rb_v = ~rval; fin = 0;
        if (slot_go) begin
            if (sidx + 1 != c_drop) begin
                rcnt = c_lat[sidx]; rpend = 1; rkind = slot_wr;
                rval = (sidx == 0) ? c_id : c_cmp;
                rb_v = ~rval;
            end
            sidx++;
        end else if (rpend) begin
            rcnt--;
            if (rcnt == 0) begin
                rpend = 0; fin = 1;
                if (rkind) tx_v = 1;
                else begin rx_v = 1; rb_v = rval; end
            end
        end
        if (c_spur && rpend && !fin) begin
            if (rkind) rx_v = 1; else tx_v = 1;
        end
        req_v = 0; pf_v = ~c_pref;
        if (start_pend) begin
            req_v = 1; pf_v = c_pref; start_pend = 0;
            sidx = 0; rpend = 0;
        end else if (c_spam && m_ph == 1) begin
            req_v = 1;
        end
        step_req = req_v; step_pref = pf_v;
        slot_rx_done = rx_v; slot_tx_done = tx_v; slot_rbit = rb_v;

        // reference model for the next clock edge
        go_now = e_go;
        e_go = 0; e_done = 0; e_err = 0;
        if (m_ph == 0) begin
            if (req_v) begin
                m_ph = 1; m_w = 0; e_go = 1; e_wr = 0; m_pref = pf_v;
            end
        end else begin
            bit ack;
            ack = ((m_ph == 3) ? tx_v : rx_v) && !go_now;
            if (ack) begin
                if (m_ph == 1) begin
                    m_id = rb_v; m_ph = 2; m_w = 0; e_go = 1; e_wr = 0;
                end else if (m_ph == 2) begin
                    m_cmp = rb_v;
                    if (m_id && m_cmp) begin
                        e_done = 1; e_code = 3'b011; m_ph = 0;
                    end else begin
                        m_dir = (m_id != m_cmp) ? m_id : m_pref;
                        e_code = {m_dir, m_cmp, m_id};
                        e_go = 1; e_wr = 1; e_wbit = m_dir; m_ph = 3; m_w = 0;
                    end
                end else begin
                    e_done = 1; m_ph = 0;
                end
            end else if (m_w == LIM - 1) begin
                e_done = 1; e_err = 1; e_code = 3'b011; m_ph = 0;
            end else begin
                m_w++;
            end
        end
        if (e_done) step_end = 1;
    end

    task automatic do_step(input bit id, input bit cmp, input bit pf,
                           input int l0, input int l1, input int l2, input int drp,
                           input bit spam, input bit spur, input string tg);
        c_id = id; c_cmp = cmp; c_pref = pf;
        c_lat[0] = l0; c_lat[1] = l1; c_lat[2] = l2;
        c_drop = drp; c_spam = spam; c_spur = spur; cur_tag = tg;
        step_end = 0;
        start_pend = 1;
        wait (step_end);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        c_lat[0] = 1; c_lat[1] = 1; c_lat[2] = 1; c_drop = 0;
        repeat (3) @(posedge clk);
        #1;
        // R9: state right after reset
        chk({step_done, step_err, slot_go}, 3'b000, "R9", "reset outputs");
        chk(step_code, 3'b000, "R9", "reset code");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        run = 1;
        repeat (2) @(posedge clk);

        // R3: both branches, either preference
        do_step(0, 0, 0, 1, 2, 1, 0, 0, 0, "R1");
        do_step(0, 0, 1, 2, 1, 3, 0, 0, 0, "R3");
        // R4: single branch forces direction
        do_step(1, 0, 0, 1, 1, 1, 0, 0, 0, "R4");
        do_step(0, 1, 1, 3, 2, 2, 0, 0, 0, "R4");
        // R2: no responder, no write slot
        do_step(1, 1, 1, 1, 1, 1, 0, 0, 0, "R2");
        do_step(1, 1, 0, 4, 2, 1, 0, 0, 0, "R2");
        // R6: latest accepted completion, then one cycle too late
        do_step(1, 0, 1, LIM - 1, LIM - 1, LIM - 1, 0, 0, 0, "R6");
        do_step(0, 0, 1, LIM, 1, 1, 0, 0, 0, "R6");
        do_step(0, 0, 1, 1, LIM, 1, 0, 0, 0, "R6");
        do_step(0, 1, 0, 1, 1, 1, 3, 0, 0, "R6");
        do_step(1, 0, 0, 2, 2, 1, 2, 0, 0, "R6");
        // R7: requests while busy
        do_step(0, 0, 1, 4, 2, 2, 0, 1, 0, "R7");
        do_step(1, 1, 0, 5, 1, 1, 0, 1, 0, "R7");
        // R5: completions of the wrong kind while a slot is pending
        do_step(0, 0, 0, 4, 3, 4, 0, 0, 1, "R5");
        do_step(1, 0, 1, 2, 5, 3, 0, 0, 1, "R5");
        // R8: back-to-back steps
        for (int k = 0; k < 8; k++)
            do_step(k[0], k[1], k[2], 1 + k % 3, 2, 1 + k % 2, 0, 0, 0, "R8");

        repeat (4) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule